// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block connects a 16-bit register-mapped host port to an 8-bit NAND flash device. The host writes a mode byte whose bits drive the NAND control lines directly: command latch, address latch, chip enable, write protect, plus the ECC and power selection fields that neighbouring logic decodes. Accesses to the data register then become NAND byte cycles. A 16-bit access becomes two byte cycles, low byte first. An 8-bit access becomes one byte cycle.

A status register reports the device's ready/busy line after synchronisation. A rising edge of that line, which marks the end of a program or erase operation, latches an event bit. The interrupt output is that bit gated by a mask bit. Each host access is held off until every NAND byte cycle it needs has finished. Completion is then signalled by a one-cycle ready pulse.

Top module: `nand_hbridge`

## Requirements
- R1: After reset the mode byte is 0x00, so chip enable is inactive (`nand_ce_n`=1), `nand_cle`=0, `nand_ale`=0, `nand_wp_n`=0, both strobes are high, and `irq`=0.
- R2: The mode register at byte offset 0x04 reads back as written. Its bits map straight onto pins: bit0 to `nand_cle`, bit1 to `nand_ale`, bits 3:2 to `pwr_ctl`, bit4 to chip enable (`nand_ce_n` is its inverse), bits 6:5 to `ecc_sel`, and bit7 to `nand_wp_n`.
- R3: With chip enable set, a 16-bit write to the data register at offset 0x00 makes two NAND write cycles. The first carries bits 7:0 and the second bits 15:8. In each cycle `nand_we_n` is low for exactly STROBE_CLKS clocks and `nand_dout` stays steady while it is low.
- R4: With chip enable set, a 16-bit read of the data register makes two cycles with `nand_re_n` low. The first byte read returns in bits 7:0 and the second in bits 15:8.
- R5: An 8-bit data access makes exactly one NAND cycle and uses host bits 7:0. A read returns the byte in bits 7:0 with bits 15:8 zero.
- R6: While chip enable (mode bit4) is clear, data accesses complete with no NAND strobe, and reads return 0.
- R7: `host_ready` is a single-cycle pulse. It comes only after every byte cycle of the access has finished, and both strobes are high while it is asserted.
- R8: The status register at offset 0x05 reads 0x80 while the synchronised `nand_rb` is low (busy) and 0x00 while it is high.
- R9: A rising edge on `nand_rb` sets event bit0 of the register at offset 0x06. A falling edge does not. Writing a 1 to bit0 clears it, and a new edge in the same cycle wins over the clear.
- R10: `irq` equals event bit0 AND bit0 of the mask register at offset 0x07. The mask register reads back as written (0x81 enables, 0x00 disables). Masking does not clear the event bit.
- R11: `nand_we_n` and `nand_re_n` are never low together, and neither goes low while chip enable is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Access request, held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit (bits 7:0) |
| host_addr | input | 3 | Byte offset of the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with `host_ready` |
| host_ready | output | 1 | One-cycle completion pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dout | output | 8 | Data to the device |
| nand_doe | output | 1 | Output enable for `nand_dout` |
| nand_din | input | 8 | Data from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |
| ecc_sel | output | 2 | ECC mode field for the ECC engine |
| pwr_ctl | output | 2 | Power control field |
| irq | output | 1 | Ready-request interrupt |

## Verification
The embedded properties check on every clock that the strobes never overlap or fire without chip enable, that write data holds still under a low write strobe, that completion is a single pulse seen with idle strobes, and that a synchronised rising edge of ready/busy always leaves the event bit set. Only the bench scenarios can show byte order across the two halves of a 16-bit access, the exact strobe width, the absence of cycles while chip enable is off, the status and event values read back through the host port, and the masking of the interrupt. The bench's reference model tracks the mode and mask bytes and compares the pin mapping and interrupt gating against them on every clock.

// File: rtl/nand_hb_pkg.sv
package nand_hb_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_MODE = 3'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'h5;
  localparam logic [ADDR_W-1:0] OFS_EVNT = 3'h6;
  localparam logic [ADDR_W-1:0] OFS_MASK = 3'h7;

  localparam int MB_CLE  = 0;
  localparam int MB_ALE  = 1;
  localparam int MB_PWR  = 2;
  localparam int MB_CE   = 4;
  localparam int MB_ECC  = 5;
  localparam int MB_WPN  = 7;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_STRB = 2'd1,
    SQ_RCOV = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    HC_IDLE = 2'd0,
    HC_LO   = 2'd1,
    HC_HI   = 2'd2,
    HC_ACK  = 2'd3
  } host_state_t;

endpackage

// File: rtl/nand_hb_regs.sv
module nand_hb_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       evnt_we,
  input  logic       mask_we,
  input  logic [7:0] wbyte,
  input  logic       nand_rb,
  output logic [7:0] mode_q,
  output logic       evnt_q,
  output logic [7:0] mask_q,
  output logic       busy,
  output logic       irq
);

  logic [2:0] rb_pipe_q;
  logic       rb_rise;
  logic       evnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_pipe_q <= 3'b111;
    else        rb_pipe_q <= {rb_pipe_q[1:0], nand_rb};
  end

  assign rb_rise = rb_pipe_q[1] & ~rb_pipe_q[2];
  assign busy    = ~rb_pipe_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 8'h00;
    else if (mode_we) mode_q <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 8'h00;
    else if (mask_we) mask_q <= wbyte;
  end

  always_comb begin
    evnt_d = evnt_q;
    if (evnt_we && wbyte[0]) evnt_d = 1'b0;
    if (rb_rise)             evnt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evnt_q <= 1'b0;
    else        evnt_q <= evnt_d;
  end

  assign irq = evnt_q & mask_q[0];

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> evnt_q); // R9

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evnt_q && !(evnt_we && wbyte[0])) |=> evnt_q); // R9

endmodule

// File: rtl/nand_hb_seq.sv
module nand_hb_seq
  import nand_hb_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int RECOV_CLKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic [7:0] nand_din,
  output logic       done,
  output logic [7:0] rbyte,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] nand_dout,
  output logic       nand_doe
);

  localparam int CNT_MAX = (STROBE_CLKS > RECOV_CLKS) ? STROBE_CLKS : RECOV_CLKS;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] STRB_LOAD = CW'(STROBE_CLKS - 1);
  localparam logic [CW-1:0] RCOV_LOAD = CW'(RECOV_CLKS - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic [7:0]    db_q, db_d;
  logic [7:0]    rb_q, rb_d;
  logic          accept;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    db_d   = db_q;
    rb_d   = rb_q;
    done   = 1'b0;
    accept = (st_q == SQ_IDLE) || (st_q == SQ_RCOV && cnt_q == '0);
    case (st_q)
      SQ_STRB: begin
        if (cnt_q == '0) begin
          if (!wr_q) rb_d = nand_din;
          st_d  = SQ_RCOV;
          cnt_d = RCOV_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_RCOV: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          st_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ;
    endcase
    if (accept && start) begin
      st_d  = SQ_STRB;
      cnt_d = STRB_LOAD;
      wr_d  = wr;
      db_d  = wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      db_q  <= 8'h00;
      rb_q  <= 8'h00;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      db_q  <= db_d;
      rb_q  <= rb_d;
    end
  end

  assign rbyte     = rb_q;
  assign nand_we_n = !(st_q == SQ_STRB && wr_q);
  assign nand_re_n = !(st_q == SQ_STRB && !wr_q);
  assign nand_dout = db_q;
  assign nand_doe  = wr_q && (st_q != SQ_IDLE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R11

  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dout)); // R3

endmodule

// File: rtl/nand_hb_ctrl.sv
module nand_hb_ctrl
  import nand_hb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic              host_wide,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_ready,
  input  logic [7:0]        mode_q,
  input  logic              evnt_q,
  input  logic [7:0]        mask_q,
  input  logic              busy,
  output logic              mode_we,
  output logic              evnt_we,
  output logic              mask_we,
  output logic              seq_start,
  output logic              seq_wr,
  output logic [7:0]        seq_byte,
  input  logic              seq_done,
  input  logic [7:0]        seq_rbyte
);

  host_state_t st_q, st_d;
  logic [15:0] rd_q, rd_d;
  logic [7:0]  hi_q, hi_d;
  logic        wr_q, wr_d;
  logic        wide_q, wide_d;
  logic [7:0]  reg_rd;

  always_comb begin
    case (host_addr)
      OFS_MODE: reg_rd = mode_q;
      OFS_STAT: reg_rd = {busy, 7'b0};
      OFS_EVNT: reg_rd = {7'b0, evnt_q};
      OFS_MASK: reg_rd = mask_q;
      default:  reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    rd_d      = rd_q;
    hi_d      = hi_q;
    wr_d      = wr_q;
    wide_d    = wide_q;
    seq_start = 1'b0;
    seq_byte  = 8'h00;
    seq_wr    = wr_q;
    mode_we   = 1'b0;
    evnt_we   = 1'b0;
    mask_we   = 1'b0;
    case (st_q)
      HC_IDLE: begin
        seq_wr = host_write;
        if (host_valid) begin
          hi_d   = host_wdata[15:8];
          wr_d   = host_write;
          wide_d = host_wide;
          rd_d   = 16'h0000;
          st_d   = HC_ACK;
          if (host_addr == OFS_DATA) begin
            if (mode_q[MB_CE]) begin
              seq_start = 1'b1;
              seq_byte  = host_wdata[7:0];
              st_d      = HC_LO;
            end
          end else if (host_write) begin
            mode_we = (host_addr == OFS_MODE);
            evnt_we = (host_addr == OFS_EVNT);
            mask_we = (host_addr == OFS_MASK);
          end else begin
            rd_d = {8'h00, reg_rd};
          end
        end
      end
      HC_LO: begin
        if (seq_done) begin
          if (!wr_q) rd_d[7:0] = seq_rbyte;
          if (wide_q) begin
            seq_start = 1'b1;
            seq_byte  = hi_q;
            st_d      = HC_HI;
          end else begin
            st_d = HC_ACK;
          end
        end
      end
      HC_HI: begin
        if (seq_done) begin
          if (!wr_q) rd_d[15:8] = seq_rbyte;
          st_d = HC_ACK;
        end
      end
      default: st_d = HC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HC_IDLE;
      rd_q   <= 16'h0000;
      hi_q   <= 8'h00;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      hi_q   <= hi_d;
      wr_q   <= wr_d;
      wide_q <= wide_d;
    end
  end

  assign host_rdata = rd_q;
  assign host_ready = (st_q == HC_ACK);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready); // R7

endmodule

// File: rtl/nand_hbridge.sv
module nand_hbridge
  import nand_hb_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int RECOV_CLKS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic        host_wide,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_ready,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_ce_n,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic [7:0]  nand_dout,
  output logic        nand_doe,
  input  logic [7:0]  nand_din,
  input  logic        nand_rb,
  output logic [1:0]  ecc_sel,
  output logic [1:0]  pwr_ctl,
  output logic        irq
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic [7:0] mode_q, mask_q;
  logic       evnt_q, busy;
  logic       mode_we, evnt_we, mask_we;
  logic       seq_start, seq_wr, seq_done;
  logic [7:0] seq_byte, seq_rbyte;

  nand_hb_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .mode_we (mode_we),
    .evnt_we (evnt_we),
    .mask_we (mask_we),
    .wbyte   (host_wdata[7:0]),
    .nand_rb (nand_rb),
    .mode_q  (mode_q),
    .evnt_q  (evnt_q),
    .mask_q  (mask_q),
    .busy    (busy),
    .irq     (irq)
  );

  nand_hb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_wide  (host_wide),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_ready (host_ready),
    .mode_q     (mode_q),
    .evnt_q     (evnt_q),
    .mask_q     (mask_q),
    .busy       (busy),
    .mode_we    (mode_we),
    .evnt_we    (evnt_we),
    .mask_we    (mask_we),
    .seq_start  (seq_start),
    .seq_wr     (seq_wr),
    .seq_byte   (seq_byte),
    .seq_done   (seq_done),
    .seq_rbyte  (seq_rbyte)
  );

  nand_hb_seq #(
    .STROBE_CLKS (STROBE_CLKS),
    .RECOV_CLKS  (RECOV_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (seq_start),
    .wr        (seq_wr),
    .wbyte     (seq_byte),
    .nand_din  (nand_din),
    .done      (seq_done),
    .rbyte     (seq_rbyte),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_dout (nand_dout),
    .nand_doe  (nand_doe)
  );

  assign nand_cle  = mode_q[MB_CLE];
  assign nand_ale  = mode_q[MB_ALE];
  assign nand_ce_n = ~mode_q[MB_CE];
  assign nand_wp_n = mode_q[MB_WPN];
  assign pwr_ctl   = mode_q[MB_PWR +: 2];
  assign ecc_sel   = mode_q[MB_ECC +: 2];

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R11

  AST_READY_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n_i)
    host_ready |-> (nand_we_n && nand_re_n)); // R7

endmodule

// File: tb/nand_hbridge_tb_top.sv
module nand_hbridge_tb_top;

  localparam int STRB = 3;
  localparam int RCOV = 2;

  logic        clk;
  logic        rst_n;
  logic        host_valid, host_write, host_wide;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic        host_ready;
  logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_wp_n;
  logic [7:0]  nand_dout, nand_din;
  logic        nand_doe, nand_rb;
  logic [1:0]  ecc_sel, pwr_ctl;
  logic        irq;

  nand_hbridge #(.STROBE_CLKS(STRB), .RECOV_CLKS(RCOV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_wide(host_wide),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
    .nand_rb(nand_rb), .ecc_sel(ecc_sel), .pwr_ctl(pwr_ctl), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit run_mon  = 1'b0;

  // reference model state
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_mask = 8'h00;
  logic [7:0] wr_log[$];
  logic [7:0] rd_src[$];
  int         strobe_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // NAND device model and per-clock comparison
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [7:0] last_dout = 8'h00;
  int   we_len = 0;
  logic prev_ready = 1'b0;

  always @(negedge clk) begin
    #1;
    if (run_mon) begin
      // R2 pin mapping against model mode byte
      chk(nand_cle == m_mode[0] && nand_ale == m_mode[1] && nand_ce_n == ~m_mode[4] &&
          nand_wp_n == m_mode[7] && pwr_ctl == m_mode[3:2] && ecc_sel == m_mode[6:5],
          "R2 pins", {nand_wp_n, ecc_sel, ~nand_ce_n, pwr_ctl, nand_ale, nand_cle}, m_mode);
      // R11 strobe exclusivity and chip enable
      chk(!(!nand_we_n && !nand_re_n), "R11 overlap", {nand_we_n, nand_re_n}, 3);
      if (!nand_we_n || !nand_re_n) chk(m_mode[4], "R11 strobe without CE", m_mode, 8'h10);
      // R10 masked interrupt never asserts
      if (!m_mask[0]) chk(irq == 1'b0, "R10 masked irq", irq, 0);
      // R7 ready pulse with idle strobes
      if (host_ready) begin
        chk(nand_we_n && nand_re_n, "R7 strobes at ready", {nand_we_n, nand_re_n}, 3);
        chk(!prev_ready, "R7 ready pulse width", 2, 1);
      end
      prev_ready = host_ready;
    end
    if (!nand_we_n) begin
      we_len++;
      last_dout = nand_dout;
    end
    if (nand_we_n && !prev_we) begin
      wr_log.push_back(last_dout);
      chk(we_len == STRB, "R3 strobe width", we_len, STRB);
      we_len = 0;
    end
    if (!nand_re_n && prev_re) begin
      nand_din = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hEE;
    end
    if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) strobe_cnt++;
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic host_acc(input bit wr, input bit wide, input logic [2:0] addr,
                          input logic [15:0] wd, output logic [15:0] rd);
    int guard;
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_wide = wide;
    host_addr = addr; host_wdata = wd;
    guard = 0;
    rd = 16'hxxxx;
    forever begin
      @(negedge clk);
      guard++;
      if (host_ready) begin
        rd = host_rdata;
        break;
      end
      if (guard > 200) begin
        chk(1'b0, "R7 ready timeout", guard, 0);
        break;
      end
    end
    host_valid = 1'b0;
    if (wr && addr == 3'h4) m_mode = wd[7:0];
    if (wr && addr == 3'h7) m_mask = wd[7:0];
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int s0;
    host_valid = 1'b0; host_write = 1'b0; host_wide = 1'b0;
    host_addr = 3'h0; host_wdata = 16'h0000;
    nand_din = 8'h00; nand_rb = 1'b1;
    rst_n = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(5);
    run_mon = 1'b1;

    // R1 reset state
    chk(nand_ce_n && !nand_cle && !nand_ale && !nand_wp_n, "R1 pins",
        {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b1000);
    chk(nand_we_n && nand_re_n && !irq && !host_ready, "R1 strobes/irq",
        {nand_we_n, nand_re_n, irq, host_ready}, 4'b1100);
    host_acc(0, 0, 3'h4, 16'h0, rd);
    chk(rd == 16'h0000, "R1 mode reset value", rd, 0);

    // R2 mode register fields
    host_acc(1, 0, 3'h4, 16'h006C, rd);
    chk(ecc_sel == 2'b11 && pwr_ctl == 2'b11 && nand_ce_n, "R2 ecc/pwr",
        {ecc_sel, pwr_ctl, nand_ce_n}, 5'b11111);
    host_acc(1, 0, 3'h4, 16'h0095, rd);
    host_acc(0, 0, 3'h4, 16'h0, rd);
    chk(rd == 16'h0095, "R2 readback", rd, 16'h0095);
    chk(nand_cle && !nand_ale && !nand_ce_n && nand_wp_n, "R2 command pins",
        {nand_cle, nand_ale, nand_ce_n, nand_wp_n}, 4'b1001);

    // R5 single byte command write
    wr_log.delete();
    host_acc(1, 0, 3'h0, 16'hAB70, rd);
    chk(wr_log.size() == 1, "R5 byte write count", wr_log.size(), 1);
    if (wr_log.size() == 1) chk(wr_log[0] == 8'h70, "R5 byte write lane", wr_log[0], 8'h70);

    // R3 wide address write, low byte first
    host_acc(1, 0, 3'h4, 16'h0096, rd);
    chk(nand_ale && !nand_cle, "R2 address pins", {nand_ale, nand_cle}, 2'b10);
    wr_log.delete();
    host_acc(1, 1, 3'h0, 16'h1234, rd);
    chk(wr_log.size() == 2, "R3 wide write count", wr_log.size(), 2);
    if (wr_log.size() == 2) begin
      chk(wr_log[0] == 8'h34, "R3 first byte", wr_log[0], 8'h34);
      chk(wr_log[1] == 8'h12, "R3 second byte", wr_log[1], 8'h12);
    end

    // R4 wide read packing, R5 byte read
    host_acc(1, 0, 3'h4, 16'h0094, rd);
    rd_src.delete();
    rd_src.push_back(8'hA5); rd_src.push_back(8'h3C);
    host_acc(0, 1, 3'h0, 16'h0, rd);
    chk(rd == 16'h3CA5, "R4 wide read order", rd, 16'h3CA5);
    rd_src.push_back(8'h77);
    s0 = strobe_cnt;
    host_acc(0, 0, 3'h0, 16'h0, rd);
    chk(rd == 16'h0077, "R5 byte read", rd, 16'h0077);
    chk(strobe_cnt - s0 == 1, "R5 byte read cycles", strobe_cnt - s0, 1);

    // R6 chip enable off: no cycles, zero read
    host_acc(1, 0, 3'h4, 16'h0000, rd);
    s0 = strobe_cnt;
    host_acc(1, 1, 3'h0, 16'hBEEF, rd);
    rd_src.push_back(8'h55);
    host_acc(0, 1, 3'h0, 16'h0, rd);
    chk(rd == 16'h0000, "R6 read while disabled", rd, 0);
    chk(strobe_cnt == s0, "R6 no strobes", strobe_cnt - s0, 0);
    rd_src.delete();

    // R8 status
    nand_rb = 1'b0;
    wait_clk(4);
    host_acc(0, 0, 3'h5, 16'h0, rd);
    chk(rd == 16'h0080, "R8 busy", rd, 16'h0080);

    // R9 falling edge did not set event
    host_acc(0, 0, 3'h6, 16'h0, rd);
    chk(rd == 16'h0000, "R9 falling edge ignored", rd, 0);

    // R10 enable mask, then ready rise
    host_acc(1, 0, 3'h6, 16'h000F, rd);
    host_acc(1, 0, 3'h7, 16'h0081, rd);
    host_acc(0, 0, 3'h7, 16'h0, rd);
    chk(rd == 16'h0081, "R10 mask readback", rd, 16'h0081);
    chk(irq == 1'b0, "R10 no event yet", irq, 0);
    nand_rb = 1'b1;
    wait_clk(5);
    chk(irq == 1'b1, "R9 R10 irq after rise", irq, 1);
    host_acc(0, 0, 3'h5, 16'h0, rd);
    chk(rd == 16'h0000, "R8 ready", rd, 0);
    host_acc(0, 0, 3'h6, 16'h0, rd);
    chk(rd == 16'h0001, "R9 event latched", rd, 1);

    // R10 masking keeps event
    host_acc(1, 0, 3'h7, 16'h0000, rd);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    host_acc(0, 0, 3'h6, 16'h0, rd);
    chk(rd == 16'h0001, "R10 event kept", rd, 1);

    // R9 clear by writing one
    host_acc(1, 0, 3'h6, 16'h000F, rd);
    host_acc(0, 0, 3'h6, 16'h0, rd);
    chk(rd == 16'h0000, "R9 clear", rd, 0);
    host_acc(1, 0, 3'h7, 16'h0081, rd);
    chk(irq == 1'b0, "R10 cleared event no irq", irq, 0);

    wait_clk(3);
    finish_run();
  end

endmodule